// File: doc/BRIEF.md
# SD Host Normal Interrupt Status Register

This block holds the normal (non-error) interrupt status of an SD host controller. Pulses from the command engine, the data engine, the DMA engine and the block-gap logic each set their own sticky status bit. A separate bit tracks the card's own interrupt line. Software reads the register through a simple register-bus port at byte address 0x30. It acknowledges events by writing ones to the bits it wants cleared. One request line goes to the system interrupt controller.

Two masks shape the block. The status-enable mask decides which events are captured and which bits a read returns. The signal-enable mask decides which captured bits drive the request line. The software-reset logic can clear the whole register, or only the bits that belong to the command path or to the data path, using single-cycle strobes.

Top module: `nis_status_reg`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it rises, every status bit is 0, `rd_data` is 0 and `irq` is 0.
- R2: The event bits sit at these positions: command done 0, transfer done 1, block-gap event 2, DMA event 3, write-buffer ready 4, read-buffer ready 5. A pulse on an event input sets its bit at the next clock edge, but only if the matching `stat_en` bit is 1 in that cycle. A pulse arriving while that enable bit is 0 is dropped.
- R3: When `bus_addr` equals 0x30, `rd_data` is the status vector ANDed with `stat_en`. At any other address it is 0. `sig_en` never changes `rd_data`. Positions 6, 7 and 9 to 15 always read 0.
- R4: `irq` is 1 exactly when some status bit is 1 and its `sig_en` bit is also 1, whatever `stat_en` holds.
- R5: A write (`bus_wr`=1, `bus_addr`=0x30) clears, at the next edge, every event bit whose `bus_wdata` bit is 1. Bits written with 0 keep their value. A write to any other address changes nothing.
- R6: If an enabled event pulse and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R7: The card-interrupt bit, at position 8, takes the value of `card_lvl` AND `stat_en[8]` from the previous cycle. Writing 1 to it has no effect.
- R8: A `rst_dat` strobe clears bits 1 to 5 at the next edge. This takes priority over same-cycle events, and bits 0 and 8 are left alone.
- R9: A `rst_cmd` strobe clears bit 0 at the next edge. This takes priority over a same-cycle event, and all other bits are left alone.
- R10: A `rst_all` strobe clears every bit, including bit 8, at the next edge. In the cycle after that, bit 8 follows `card_lvl` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address, used for both read and write |
| bus_wdata | input | 16 | Write data; a 1 requests a clear |
| ev_cmd_done | input | 1 | Command complete pulse |
| ev_xfer_done | input | 1 | Transfer complete pulse |
| ev_gap | input | 1 | Block-gap event pulse |
| ev_dma | input | 1 | DMA event pulse |
| ev_wr_rdy | input | 1 | Write buffer ready pulse |
| ev_rd_rdy | input | 1 | Read buffer ready pulse |
| card_lvl | input | 1 | Card interrupt level |
| stat_en | input | 16 | Status-enable mask (capture and read) |
| sig_en | input | 16 | Signal-enable mask (request line) |
| rst_all | input | 1 | Clear-everything strobe |
| rst_cmd | input | 1 | Command-path clear strobe |
| rst_dat | input | 1 | Data-path clear strobe |
| rd_data | output | 16 | Masked read value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are collisions within a single cycle. One is an enabled event pulse landing together with a write-one clear and with a path-reset strobe. Another is a `rst_all` strobe arriving while the card line is held high, which has to be seen coming back on the very next cycle. Random traffic almost never lines these up. So directed phases force each collision on purpose, and then a long random run with dense event pulses and sparse strobes is compared against a behavioural model on every cycle.

// File: rtl/nis_pkg.sv
package nis_pkg;

   localparam int NIS_W       = 16;
   localparam int NIS_ADDR_W  = 8;
   localparam logic [NIS_ADDR_W-1:0] NIS_OFFSET = 8'h30;

   localparam int POS_CMD  = 0;
   localparam int POS_XFER = 1;
   localparam int POS_GAP  = 2;
   localparam int POS_DMA  = 3;
   localparam int POS_WRDY = 4;
   localparam int POS_RRDY = 5;
   localparam int POS_CARD = 8;
   localparam int NUM_EV   = 6;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_STICK = 2'd1,
      KIND_LEVEL = 2'd2
   } bit_kind_e;

   function automatic bit_kind_e kind_of(input int pos);
      if (pos >= POS_CMD && pos <= POS_RRDY) return KIND_STICK;
      if (pos == POS_CARD)                   return KIND_LEVEL;
      return KIND_NONE;
   endfunction

   function automatic logic [NIS_W-1:0] cmd_group();
      logic [NIS_W-1:0] m;
      m = '0;
      m[POS_CMD] = 1'b1;
      return m;
   endfunction

   function automatic logic [NIS_W-1:0] dat_group();
      logic [NIS_W-1:0] m;
      m = '0;
      for (int i = POS_XFER; i <= POS_RRDY; i++) m[i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/nis_bit_cell.sv
module nis_bit_cell
   import nis_pkg::*;
#(
   parameter bit_kind_e KIND = KIND_STICK
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev,
   input  logic en,
   input  logic w1c,
   input  logic grp_clr,
   input  logic clr_all,
   input  logic lvl,
   output logic q
);

   generate
      if (KIND == KIND_STICK) begin : g_stick
         logic st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                st_q <= 1'b0;
            else if (clr_all || grp_clr) st_q <= 1'b0;
            else if (ev && en)         st_q <= 1'b1;
            else if (w1c)              st_q <= 1'b0;
         end
         assign q = st_q;
      end else if (KIND == KIND_LEVEL) begin : g_level
         logic lv_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       lv_q <= 1'b0;
            else if (clr_all) lv_q <= 1'b0;
            else              lv_q <= lvl & en;
         end
         assign q = lv_q;
      end else begin : g_none
         assign q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/nis_clr_decode.sv
module nis_clr_decode
   import nis_pkg::*;
#(
   parameter int W = NIS_W,
   parameter int AW = NIS_ADDR_W,
   parameter logic [AW-1:0] OFFSET = NIS_OFFSET
) (
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [W-1:0]  bus_wdata,
   input  logic          rst_cmd,
   input  logic          rst_dat,
   output logic [W-1:0]  w1c_mask,
   output logic [W-1:0]  grp_mask
);

   localparam logic [W-1:0] CMD_M = W'(cmd_group());
   localparam logic [W-1:0] DAT_M = W'(dat_group());

   logic hit;
   assign hit = bus_wr && (bus_addr == OFFSET);

   always_comb begin
      w1c_mask = hit ? bus_wdata : '0;
      grp_mask = '0;
      if (rst_cmd) grp_mask = grp_mask | CMD_M;
      if (rst_dat) grp_mask = grp_mask | DAT_M;
   end

endmodule

// File: rtl/nis_read_irq.sv
module nis_read_irq
   import nis_pkg::*;
#(
   parameter int W = NIS_W,
   parameter int AW = NIS_ADDR_W,
   parameter logic [AW-1:0] OFFSET = NIS_OFFSET
) (
   input  logic [W-1:0]  status,
   input  logic [W-1:0]  stat_en,
   input  logic [W-1:0]  sig_en,
   input  logic [AW-1:0] bus_addr,
   output logic [W-1:0]  rd_data,
   output logic          irq
);

   logic [W-1:0] vis;
   assign vis     = status & stat_en;
   assign rd_data = (bus_addr == OFFSET) ? vis : '0;
   assign irq     = |(status & sig_en);

endmodule

// File: rtl/nis_status_reg.sv
module nis_status_reg
   import nis_pkg::*;
#(
   parameter int W = NIS_W,
   parameter int AW = NIS_ADDR_W,
   parameter logic [AW-1:0] OFFSET = NIS_OFFSET
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [W-1:0]  bus_wdata,
   input  logic          ev_cmd_done,
   input  logic          ev_xfer_done,
   input  logic          ev_gap,
   input  logic          ev_dma,
   input  logic          ev_wr_rdy,
   input  logic          ev_rd_rdy,
   input  logic          card_lvl,
   input  logic [W-1:0]  stat_en,
   input  logic [W-1:0]  sig_en,
   input  logic          rst_all,
   input  logic          rst_cmd,
   input  logic          rst_dat,
   output logic [W-1:0]  rd_data,
   output logic          irq
);

   generate
      if (W <= POS_CARD) begin : g_bad_width
         $error("nis_status_reg: W must exceed the card bit position");
      end
      if (AW < 6) begin : g_bad_addr
         $error("nis_status_reg: AW too small for register offset");
      end
   endgenerate

   logic [W-1:0] ev_vec;
   logic [W-1:0] w1c_mask;
   logic [W-1:0] grp_mask;
   logic [W-1:0] stat_q;

   always_comb begin
      ev_vec           = '0;
      ev_vec[POS_CMD]  = ev_cmd_done;
      ev_vec[POS_XFER] = ev_xfer_done;
      ev_vec[POS_GAP]  = ev_gap;
      ev_vec[POS_DMA]  = ev_dma;
      ev_vec[POS_WRDY] = ev_wr_rdy;
      ev_vec[POS_RRDY] = ev_rd_rdy;
   end

   nis_clr_decode #(.W(W), .AW(AW), .OFFSET(OFFSET)) u_dec (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .rst_cmd  (rst_cmd),
      .rst_dat  (rst_dat),
      .w1c_mask (w1c_mask),
      .grp_mask (grp_mask)
   );

   for (genvar i = 0; i < W; i++) begin : g_bit
      nis_bit_cell #(.KIND(kind_of(i))) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .ev     (ev_vec[i]),
         .en     (stat_en[i]),
         .w1c    (w1c_mask[i]),
         .grp_clr(grp_mask[i]),
         .clr_all(rst_all),
         .lvl    (card_lvl),
         .q      (stat_q[i])
      );
   end

   nis_read_irq #(.W(W), .AW(AW), .OFFSET(OFFSET)) u_out (
      .status  (stat_q),
      .stat_en (stat_en),
      .sig_en  (sig_en),
      .bus_addr(bus_addr),
      .rd_data (rd_data),
      .irq     (irq)
   );

endmodule

// File: rtl/nis_status_reg_chk.sv
module nis_status_reg_chk
   import nis_pkg::*;
#(
   parameter int W = NIS_W,
   parameter int AW = NIS_ADDR_W,
   parameter logic [AW-1:0] OFFSET = NIS_OFFSET
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [AW-1:0] bus_addr,
   input logic [W-1:0]  bus_wdata,
   input logic          ev_cmd_done,
   input logic          ev_xfer_done,
   input logic          card_lvl,
   input logic [W-1:0]  stat_en,
   input logic [W-1:0]  sig_en,
   input logic          rst_all,
   input logic          rst_cmd,
   input logic          rst_dat,
   input logic [W-1:0]  rd_data,
   input logic          irq,
   input logic [W-1:0]  stat_q
);

   logic hit;
   assign hit = bus_wr && (bus_addr == OFFSET);

   p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (stat_q == '0 && !irq));

   p_masked_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[POS_CMD] && ev_cmd_done && !stat_en[POS_CMD]) |=> !stat_q[POS_CMD]);

   p_other_addr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != OFFSET) |-> (rd_data == '0));

   p_irq_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_cmd_done && stat_en[POS_CMD] && !rst_all && !rst_cmd && sig_en[POS_CMD])
      |=> (irq || !sig_en[POS_CMD]));

   p_w1c_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && bus_wdata[POS_CMD] && !ev_cmd_done) |=> !stat_q[POS_CMD]);

   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && bus_wdata[POS_XFER] && ev_xfer_done && stat_en[POS_XFER]
       && !rst_all && !rst_dat) |=> stat_q[POS_XFER]);

   p_card_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_all |=> (stat_q[POS_CARD] == $past(card_lvl && stat_en[POS_CARD])));

   p_dat_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_dat |=> (stat_q[POS_RRDY:POS_XFER] == '0));

   p_cmd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_cmd |=> !stat_q[POS_CMD]);

   p_all_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_all |=> (stat_q == '0));

endmodule

bind nis_status_reg nis_status_reg_chk #(.W(W), .AW(AW), .OFFSET(OFFSET)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .ev_cmd_done (ev_cmd_done),
   .ev_xfer_done(ev_xfer_done),
   .card_lvl    (card_lvl),
   .stat_en     (stat_en),
   .sig_en      (sig_en),
   .rst_all     (rst_all),
   .rst_cmd     (rst_cmd),
   .rst_dat     (rst_dat),
   .rd_data     (rd_data),
   .irq         (irq),
   .stat_q      (stat_q)
);

// File: tb/tb_nis_status_reg.sv
module tb_nis_status_reg;

   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [W-1:0]  bus_wdata = '0;
   logic          ev_cmd_done = 1'b0, ev_xfer_done = 1'b0, ev_gap = 1'b0;
   logic          ev_dma = 1'b0, ev_wr_rdy = 1'b0, ev_rd_rdy = 1'b0;
   logic          card_lvl = 1'b0;
   logic [W-1:0]  stat_en = '0;
   logic [W-1:0]  sig_en = '0;
   logic          rst_all = 1'b0, rst_cmd = 1'b0, rst_dat = 1'b0;
   logic [W-1:0]  rd_data;
   logic          irq;

   int checks = 0;
   int fails = 0;
   string tag = "R1";
   bit done = 1'b0;

   // reference state: one bit per position, integers for clarity
   int ref_bit [W];

   always #(CLK_PERIOD/2) clk = ~clk;

   nis_status_reg dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .ev_cmd_done(ev_cmd_done), .ev_xfer_done(ev_xfer_done),
      .ev_gap(ev_gap), .ev_dma(ev_dma), .ev_wr_rdy(ev_wr_rdy), .ev_rd_rdy(ev_rd_rdy),
      .card_lvl(card_lvl), .stat_en(stat_en), .sig_en(sig_en), .rst_all(rst_all),
      .rst_cmd(rst_cmd), .rst_dat(rst_dat), .rd_data(rd_data), .irq(irq)
   );

   function automatic bit ev_at(int p);
      case (p)
         0: return ev_cmd_done;
         1: return ev_xfer_done;
         2: return ev_gap;
         3: return ev_dma;
         4: return ev_wr_rdy;
         5: return ev_rd_rdy;
         default: return 1'b0;
      endcase
   endfunction

   // behavioural model update at each rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < W; i++) ref_bit[i] = 0;
      end else begin
         bit wr_hit;
         wr_hit = bus_wr && (bus_addr == 8'h30);
         for (int i = 0; i < W; i++) begin
            if (i <= 5) begin
               if (rst_all) ref_bit[i] = 0;
               else if (rst_cmd && i == 0) ref_bit[i] = 0;
               else if (rst_dat && i >= 1) ref_bit[i] = 0;
               else if (ev_at(i) && stat_en[i]) ref_bit[i] = 1;
               else if (wr_hit && bus_wdata[i]) ref_bit[i] = 0;
            end else if (i == 8) begin
               ref_bit[i] = rst_all ? 0 : ((card_lvl && stat_en[8]) ? 1 : 0);
            end
         end
      end
   end

   task automatic compare();
      logic [W-1:0] exp_rd;
      logic exp_irq;
      exp_rd = '0;
      exp_irq = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (ref_bit[i] != 0 && bus_addr == 8'h30 && stat_en[i]) exp_rd[i] = 1'b1;
         if (ref_bit[i] != 0 && sig_en[i]) exp_irq = 1'b1;
      end
      checks++;
      if (rd_data !== exp_rd) begin
         fails++;
         $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, exp_rd);
      end
      checks++;
      if (irq !== exp_irq) begin
         fails++;
         $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_irq);
      end
   endtask

   task automatic check_val(string t, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", t, act, exp);
      end
   endtask

   task automatic clear_inputs();
      bus_wr = 0; bus_wdata = '0;
      ev_cmd_done = 0; ev_xfer_done = 0; ev_gap = 0; ev_dma = 0;
      ev_wr_rdy = 0; ev_rd_rdy = 0;
      rst_all = 0; rst_cmd = 0; rst_dat = 0;
   endtask

   // advance one cycle: wait for the edge to consume inputs, then compare at the next half cycle
   task automatic tick();
      @(negedge clk);
      #1;
      compare();
   endtask

   task automatic read_at_reg();
      clear_inputs();
      bus_addr = 8'h30;
      #1;
      compare();
   endtask

   initial begin
      // R1: reset state
      tag = "R1";
      stat_en = '1; sig_en = '1; bus_addr = 8'h30;
      repeat (3) @(negedge clk);
      check_val("R1 rd_data in reset", rd_data, '0);
      check_val("R1 irq in reset", {15'd0, irq}, '0);
      rst_n = 1'b1;
      tick();

      // R2: enabled events latch, masked events dropped
      tag = "R2";
      stat_en = 16'h0005; sig_en = '0;
      ev_cmd_done = 1; ev_xfer_done = 1; ev_gap = 1; ev_dma = 1;
      tick();
      clear_inputs();
      stat_en = '1;
      read_at_reg();
      check_val("R2 only enabled bits latched", rd_data, 16'h0005);

      // R3: read masking, other address, sig_en no effect
      tag = "R3";
      stat_en = 16'h0004; sig_en = '1;
      #1; check_val("R3 masked read", rd_data, 16'h0004);
      bus_addr = 8'h34; #1;
      check_val("R3 other address reads zero", rd_data, '0);
      bus_addr = 8'h30; stat_en = '1; sig_en = '0; #1;
      check_val("R3 sig_en does not affect read", rd_data, 16'h0005);

      // R4: irq gated by sig_en only
      tag = "R4";
      stat_en = '0; sig_en = 16'h0004; #1;
      check_val("R4 irq with stat_en low", {15'd0, irq}, 16'h0001);
      sig_en = 16'h0002; #1;
      check_val("R4 irq off for clear bit", {15'd0, irq}, '0);
      stat_en = '1;

      // R5: W1C, multi-bit, zero keeps, wrong address ignored
      tag = "R5";
      bus_wr = 1; bus_addr = 8'h31; bus_wdata = 16'hFFFF;
      tick();
      clear_inputs();
      read_at_reg();
      check_val("R5 write to other address ignored", rd_data, 16'h0005);
      bus_wr = 1; bus_addr = 8'h30; bus_wdata = 16'h0004;
      tick();
      clear_inputs();
      read_at_reg();
      check_val("R5 one bit cleared, other kept", rd_data, 16'h0001);
      ev_dma = 1; ev_gap = 1; tick(); clear_inputs();
      bus_wr = 1; bus_wdata = 16'h000D; tick(); clear_inputs();
      read_at_reg();
      check_val("R5 several bits cleared at once", rd_data, '0);

      // R6: set beats clear
      tag = "R6";
      ev_xfer_done = 1; tick(); clear_inputs();
      ev_xfer_done = 1; bus_wr = 1; bus_wdata = 16'h0002; tick(); clear_inputs();
      read_at_reg();
      check_val("R6 set wins over write clear", rd_data, 16'h0002);

      // R7: card bit follows level, write ignored
      tag = "R7";
      card_lvl = 1; tick();
      bus_wr = 1; bus_wdata = 16'h0100; tick(); clear_inputs();
      read_at_reg();
      check_val("R7 card bit not cleared by write", rd_data & 16'h0100, 16'h0100);
      card_lvl = 0; tick();
      check_val("R7 card bit drops with level", rd_data & 16'h0100, '0);

      // R8 / R9: path resets
      tag = "R8";
      card_lvl = 1;
      ev_cmd_done = 1; ev_gap = 1; ev_wr_rdy = 1; ev_rd_rdy = 1; tick(); clear_inputs();
      rst_dat = 1; ev_dma = 1; tick(); clear_inputs();
      read_at_reg();
      check_val("R8 data reset keeps cmd and card", rd_data, 16'h0101);
      tag = "R9";
      ev_gap = 1; tick(); clear_inputs();
      rst_cmd = 1; ev_cmd_done = 1; tick(); clear_inputs();
      read_at_reg();
      check_val("R9 cmd reset clears only bit 0", rd_data, 16'h0104);

      // R10: reset-all then card refollows
      tag = "R10";
      rst_all = 1; tick(); clear_inputs();
      check_val("R10 all bits cleared", rd_data, '0);
      tick();
      check_val("R10 card bit back next cycle", rd_data, 16'h0100);

      // random run with per-cycle comparison
      tag = "R2";
      for (int n = 0; n < 4000; n++) begin
         int sel;
         sel = n % 6;
         tag = (sel == 0) ? "R2" : (sel == 1) ? "R3" : (sel == 2) ? "R4" :
               (sel == 3) ? "R5" : (sel == 4) ? "R6" : "R7";
         ev_cmd_done  = ($urandom % 3) == 0;
         ev_xfer_done = ($urandom % 3) == 0;
         ev_gap       = ($urandom % 4) == 0;
         ev_dma       = ($urandom % 4) == 0;
         ev_wr_rdy    = ($urandom % 4) == 0;
         ev_rd_rdy    = ($urandom % 4) == 0;
         card_lvl     = ($urandom % 5) != 0 ? card_lvl : ~card_lvl;
         stat_en      = ($urandom % 8) == 0 ? W'($urandom) : '1;
         sig_en       = W'($urandom);
         bus_wr       = ($urandom % 3) == 0;
         bus_addr     = ($urandom % 4) == 0 ? 8'h2C : 8'h30;
         bus_wdata    = W'($urandom);
         rst_all      = ($urandom % 61) == 0;
         rst_cmd      = ($urandom % 23) == 0;
         rst_dat      = ($urandom % 19) == 0;
         tick();
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule